// File: doc/BRIEF.md
# Three-Channel PWM Timer with Level Polarity

This block is a 16-bit up-counter that produces three pulse-width-modulated outputs. One period register sets the length of the cycle for all three outputs. Each output has its own duty register. An output switches to its active level when the counter moves past that output's duty value. It switches back to its inactive level when the counter reaches the period value. In the usual setup the counter is also cleared to zero at that point.

Software configures the block through single-cycle write strobes on a small register file. The settings cover the counter clock source, the edge selection for the external clock, and the clear policy. For each output there is a PWM mode bit, an initial-value bit, a polarity bit and an output-enable bit. A start bit runs and stops the counter. While the counter is stopped, every pin rests at its initial level, which is the XNOR of its initial-value bit and its polarity bit. While the counter runs, the active level is the inverse of that initial level.

The counter can advance on the system clock divided by 1, 2, 4 or 8. It can also advance on edges of an asynchronous external clock, which first passes through a two-flop synchroniser.

Top module: `pwm3_timer`

## Requirements
- R1: After reset, all registers are zero, the counter reads 0 and every pin is at level 1.
- R2: While the counter is stopped, each pin shows XNOR(initial-value bit, polarity bit). The initial-value bits are in write data bits [2:0] and the polarity bits are in bits [6:4], at address 6. Bit 0 is output B, bit 1 is output C and bit 2 is output D.
- R3: The counter advances only while the start bit (address 8, bit 0) is 1. Writing the start bit to 0 freezes the counter value, and one clock later every pin is back at its initial level.
- R4: The clock select field (address 0, bits [2:0]) works as follows. Codes 0 to 3 advance the counter once every 1, 2, 4 or 8 system clocks. Code 7 selects the external clock. Codes 4 to 6 hold the counter.
- R5: With the external clock selected, the edge field (address 0, bits [4:3]) picks the edges that advance the counter by one. Code 00 selects rising edges, 01 selects falling edges, and 1x selects both.
- R6: With the clear field (address 0, bits [6:5]) set to 01, an advance taken while the counter equals the period register (address 1) loads 0. Any other clear code lets the counter run on past the period and wrap at 16'hFFFF.
- R7: With its PWM mode bit (address 5) set, an output is active while the counter value c satisfies duty < c <= period. The duty registers are at addresses 2, 3 and 4 for outputs B, C and D. The output is inactive for every other value of c. The active level is the inverse of the initial level.
- R8: An output whose duty value is greater than or equal to the period value stays at its inactive level for the whole cycle.
- R9: An output whose PWM mode bit is 0 holds its initial level while the counter runs.
- R10: An output whose enable bit (address 7) is 0 holds its initial level while the counter runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 4 | Register address |
| wrData | input | 16 | Register write data |
| extClk | input | 1 | Asynchronous external count clock |
| pwmOut | output | 3 | Waveform pins: bit 0 = B, bit 1 = C, bit 2 = D |
| countValue | output | 16 | Current counter value |

## Verification
A fault in the counter shows up on countValue at the very next advance, either as a skipped value, a missed clear at the period, or movement while the counter is stopped. A wrong waveform state bit shows up on its pin in the same cycle, because each pin is a direct function of that bit and the configuration registers. A fault in the prescaler or the edge detector only shows up as a changed spacing between counter steps. It can take up to eight clocks, or one external clock pulse, before such a fault is visible.

// File: rtl/pwm3_pkg.sv
package pwm3_pkg;

  // Strobes passed from the control block to the datapath
  typedef struct packed {
    logic run;            // start bit is set
    logic tick;           // counter advances this cycle
    logic clearOnPeriod;  // clear to zero on a period match
  } ctlStrobe_t;

  localparam logic [2:0] CLK_EXT    = 3'd7;
  localparam logic [1:0] CLR_PERIOD = 2'b01;

endpackage

// File: rtl/pwm3_ctrl.sv
module pwm3_ctrl
  import pwm3_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int NUM_CH      = 3,
  parameter int ADDR_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           wrEn,
  input  logic [ADDR_W-1:0]              wrAddr,
  input  logic [CNT_W-1:0]               wrData,
  input  logic                           extClk,
  output ctlStrobe_t                     strb,
  output logic [CNT_W-1:0]               periodVal,
  output logic [NUM_CH-1:0][CNT_W-1:0]   dutyVal,
  output logic [NUM_CH-1:0]              pwmEn,
  output logic [NUM_CH-1:0]              initVal,
  output logic [NUM_CH-1:0]              polSel,
  output logic [NUM_CH-1:0]              outEn
);

  // Register map
  localparam int ADDR_CTRL   = 0;
  localparam int ADDR_PERIOD = 1;
  localparam int ADDR_DUTY0  = 2;
  localparam int ADDR_MODE   = ADDR_DUTY0 + NUM_CH;
  localparam int ADDR_OCFG   = ADDR_MODE + 1;
  localparam int ADDR_OEN    = ADDR_OCFG + 1;
  localparam int ADDR_START  = ADDR_OEN + 1;
  localparam int POL_LSB     = NUM_CH + 1;
  localparam int PSC_W       = 3;

  logic [2:0] clkSel;
  logic [1:0] edgeSel;
  logic [1:0] clrSel;
  logic       startBit;

  // Control and output configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkSel    <= '0;
      edgeSel   <= '0;
      clrSel    <= '0;
      periodVal <= '0;
      pwmEn     <= '0;
      initVal   <= '0;
      polSel    <= '0;
      outEn     <= '0;
      startBit  <= 1'b0;
    end else if (wrEn) begin
      if (wrAddr == ADDR_W'(ADDR_CTRL)) begin
        clkSel  <= wrData[2:0];
        edgeSel <= wrData[4:3];
        clrSel  <= wrData[6:5];
      end
      if (wrAddr == ADDR_W'(ADDR_PERIOD)) periodVal <= wrData;
      if (wrAddr == ADDR_W'(ADDR_MODE))   pwmEn     <= wrData[NUM_CH-1:0];
      if (wrAddr == ADDR_W'(ADDR_OCFG)) begin
        initVal <= wrData[NUM_CH-1:0];
        polSel  <= wrData[POL_LSB+NUM_CH-1:POL_LSB];
      end
      if (wrAddr == ADDR_W'(ADDR_OEN))    outEn     <= wrData[NUM_CH-1:0];
      if (wrAddr == ADDR_W'(ADDR_START))  startBit  <= wrData[0];
    end
  end

  // One duty register per channel
  for (genvar i = 0; i < NUM_CH; i++) begin : g_duty
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        dutyVal[i] <= '0;
      else if (wrEn && wrAddr == ADDR_W'(ADDR_DUTY0 + i))
        dutyVal[i] <= wrData;
    end
  end

  // Internal prescaler: divide by 2^clkSel[1:0]
  logic [PSC_W-1:0] pscCnt;
  logic [PSC_W-1:0] pscLimit;
  logic             internalSel;

  assign internalSel = (clkSel[2] == 1'b0);
  assign pscLimit    = (PSC_W'(1) << clkSel[1:0]) - PSC_W'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      pscCnt <= '0;
    else if (!startBit || !internalSel)
      pscCnt <= '0;
    else if (pscCnt == pscLimit)
      pscCnt <= '0;
    else
      pscCnt <= pscCnt + PSC_W'(1);
  end

  // External clock synchroniser and edge detector
  logic [SYNC_STAGES-1:0] syncQ;
  logic                   extPrev;
  logic                   extNow;
  logic                   extRise;
  logic                   extFall;
  logic                   edgeHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ   <= '0;
      extPrev <= 1'b0;
    end else begin
      syncQ   <= {syncQ[SYNC_STAGES-2:0], extClk};
      extPrev <= extNow;
    end
  end

  assign extNow  = syncQ[SYNC_STAGES-1];
  assign extRise = extNow & ~extPrev;
  assign extFall = ~extNow & extPrev;

  always_comb begin
    if (edgeSel[1])      edgeHit = extRise | extFall;
    else if (edgeSel[0]) edgeHit = extFall;
    else                 edgeHit = extRise;
  end

  always_comb begin
    strb.run           = startBit;
    strb.clearOnPeriod = (clrSel == CLR_PERIOD);
    if (!startBit)
      strb.tick = 1'b0;
    else if (internalSel)
      strb.tick = (pscCnt == pscLimit);
    else
      strb.tick = (clkSel == CLK_EXT) && edgeHit;
  end

  // Codes 4 to 6 never advance the counter
  assert_reserved_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (clkSel[2] && clkSel != CLK_EXT) |-> !strb.tick);

  // An external-clock advance needs a change of the synchronised level
  assert_ext_edge_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.tick && clkSel == CLK_EXT) |-> (extNow != extPrev));

endmodule

// File: rtl/pwm3_datapath.sv
module pwm3_datapath
  import pwm3_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int NUM_CH = 3
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  ctlStrobe_t                   strb,
  input  logic [CNT_W-1:0]             periodVal,
  input  logic [NUM_CH-1:0][CNT_W-1:0] dutyVal,
  input  logic [NUM_CH-1:0]            pwmEn,
  input  logic [NUM_CH-1:0]            initVal,
  input  logic [NUM_CH-1:0]            polSel,
  input  logic [NUM_CH-1:0]            outEn,
  output logic [NUM_CH-1:0]            pwmOut,
  output logic [CNT_W-1:0]             countValue
);

  logic [CNT_W-1:0]  cnt;
  logic              periodHit;
  logic [NUM_CH-1:0] wState;
  logic [NUM_CH-1:0] initLevel;

  assign periodHit = (cnt == periodVal);

  // Counter: clears on a period match when that clear source is chosen
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      cnt <= '0;
    else if (strb.tick) begin
      if (strb.clearOnPeriod && periodHit)
        cnt <= '0;
      else
        cnt <= cnt + CNT_W'(1);
    end
  end

  // Per-channel waveform state: 1 means active
  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic dutyHit;
    logic dutyValid;

    assign dutyHit   = (cnt == dutyVal[i]);
    assign dutyValid = (dutyVal[i] < periodVal);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        wState[i] <= 1'b0;
      else if (!strb.run)
        wState[i] <= 1'b0;
      else if (strb.tick) begin
        if (periodHit)
          wState[i] <= 1'b0;
        else if (dutyHit && dutyValid)
          wState[i] <= 1'b1;
      end
    end

    // A duty value at or beyond the period never turns the output on
    assert_never_active_R8: assert property (@(posedge clk) disable iff (!rstN)
      (strb.tick && !dutyValid && !wState[i]) |=> !wState[i]);
  end

  assign initLevel  = ~(initVal ^ polSel);
  assign pwmOut     = initLevel ^ (wState & pwmEn & outEn);
  assign countValue = cnt;

  // A stopped counter holds its value
  assert_freeze_R3: assert property (@(posedge clk) disable iff (!rstN)
    !strb.run |=> $stable(cnt));

  // Stopping returns every waveform state to inactive
  assert_idle_on_stop_R3: assert property (@(posedge clk) disable iff (!rstN)
    !strb.run |=> (wState == '0));

  // The counter moves by at most one step, or clears
  assert_single_step_R4: assert property (@(posedge clk) disable iff (!rstN)
    strb.run |=> (cnt == $past(cnt) || cnt == $past(cnt) + CNT_W'(1) || cnt == '0));

  // A period match with clear enabled loads zero
  assert_period_clear_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.tick && strb.clearOnPeriod && periodHit) |=> (cnt == '0));

endmodule

// File: rtl/pwm3_timer.sv
module pwm3_timer
  import pwm3_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int NUM_CH      = 3,
  parameter int ADDR_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [CNT_W-1:0]  wrData,
  input  logic              extClk,
  output logic [NUM_CH-1:0] pwmOut,
  output logic [CNT_W-1:0]  countValue
);

  ctlStrobe_t                   strb;
  logic [CNT_W-1:0]             periodVal;
  logic [NUM_CH-1:0][CNT_W-1:0] dutyVal;
  logic [NUM_CH-1:0]            pwmEn;
  logic [NUM_CH-1:0]            initVal;
  logic [NUM_CH-1:0]            polSel;
  logic [NUM_CH-1:0]            outEn;

  pwm3_ctrl #(
    .CNT_W(CNT_W), .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .extClk(extClk), .strb(strb), .periodVal(periodVal), .dutyVal(dutyVal),
    .pwmEn(pwmEn), .initVal(initVal), .polSel(polSel), .outEn(outEn)
  );

  pwm3_datapath #(
    .CNT_W(CNT_W), .NUM_CH(NUM_CH)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .periodVal(periodVal),
    .dutyVal(dutyVal), .pwmEn(pwmEn), .initVal(initVal), .polSel(polSel),
    .outEn(outEn), .pwmOut(pwmOut), .countValue(countValue)
  );

endmodule

// File: tb/tb_pwm3_timer.sv
module tb_pwm3_timer;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [3:0]  wrAddr = '0;
  logic [15:0] wrData = '0;
  logic        extClk = 1'b0;
  logic [2:0]  pwmOut;
  logic [15:0] countValue;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  pwm3_timer dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .extClk(extClk), .pwmOut(pwmOut), .countValue(countValue)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  // Cycles between two successive counter changes
  task automatic gap(output int g);
    logic [15:0] last;
    int k;
    g = -1;
    last = countValue;
    k = 0;
    while (countValue == last && k < 20) begin @(negedge clk); k++; end
    last = countValue;
    k = 0;
    while (countValue == last && k < 20) begin @(negedge clk); k++; end
    g = k;
  endtask

  task automatic t_reset;
    check("R1", countValue, 0, "counter after reset");
    check("R1", pwmOut, 7, "pins after reset");
  endtask

  task automatic t_init_levels;
    wr(4'd6, 16'h0024);            // B:(0,0) C:(0,1) D:(1,0)
    @(negedge clk);
    check("R2", pwmOut, 3'b001, "xnor levels mixed");
    wr(4'd6, 16'h0077);            // all (1,1)
    @(negedge clk);
    check("R2", pwmOut, 3'b111, "xnor levels both set");
  endtask

  task automatic setup_wave;
    wr(4'd0, 16'h0020);            // div 1, clear on period
    wr(4'd1, 16'd9);
    wr(4'd2, 16'd3);
    wr(4'd3, 16'd0);
    wr(4'd4, 16'd12);
    wr(4'd5, 16'h0007);
    wr(4'd6, 16'h0007);            // init 1, polarity 0 -> idle 0
    wr(4'd7, 16'h0007);
  endtask

  task automatic t_gating;
    setup_wave();
    idle(5);
    check("R3", countValue, 0, "no count before start");
    check("R2", pwmOut, 0, "idle level before start");
  endtask

  task automatic t_waveform;
    int expC;
    int bad;
    int badPin;
    wr(4'd8, 16'h0001);
    expC = 0; bad = 0; badPin = 0;
    for (int k = 0; k < 25; k++) begin
      logic [2:0] e;
      if (countValue != expC) bad++;
      e[0] = (expC > 3 && expC <= 9);
      e[1] = (expC > 0 && expC <= 9);
      e[2] = 1'b0;
      if (pwmOut != e) begin
        badPin++;
        if (badPin == 1) check("R7", pwmOut, e, $sformatf("pins at count %0d", expC));
      end
      if (pwmOut[2] != 1'b0) check("R8", pwmOut[2], 0, "duty past period");
      expC = (expC == 9) ? 0 : expC + 1;
      @(negedge clk);
    end
    check("R6", bad, 0, "count sequence with clear at period");
    check("R7", badPin, 0, "waveform mismatches");
  endtask

  task automatic t_enables;
    int seenB;
    int seenC;
    int badB;
    int badC;
    wr(4'd7, 16'h0006);            // output B disabled
    seenC = 0; badB = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (pwmOut[0]) badB++;
      if (pwmOut[1]) seenC++;
    end
    check("R10", badB, 0, "disabled B left idle level");
    check("R10", seenC > 0, 1, "enabled C active");
    wr(4'd7, 16'h0007);
    wr(4'd5, 16'h0005);            // C not in PWM mode
    seenB = 0; badC = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (pwmOut[1]) badC++;
      if (pwmOut[0]) seenB++;
    end
    check("R9", badC, 0, "non-PWM C left idle level");
    check("R9", seenB > 0, 1, "PWM B active");
    wr(4'd5, 16'h0007);
  endtask

  task automatic t_stop;
    logic [15:0] frozen;
    int moved;
    wr(4'd8, 16'h0000);
    frozen = countValue;
    @(negedge clk);
    check("R3", pwmOut, 0, "pins at idle after stop");
    moved = 0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (countValue != frozen) moved++;
    end
    check("R3", moved, 0, "counter frozen after stop");
    wr(4'd6, 16'h0070);            // init 0, polarity 1 -> idle 0
    @(negedge clk);
    check("R2", pwmOut, 0, "idle with polarity only");
    wr(4'd6, 16'h0007);
  endtask

  task automatic t_prescaler;
    int g;
    wr(4'd0, 16'h0022);            // divide by 4
    wr(4'd8, 16'h0001);
    gap(g);
    check("R4", g, 4, "divide by 4 spacing");
    wr(4'd0, 16'h0021);
    gap(g);
    check("R4", g, 2, "divide by 2 spacing");
    wr(4'd0, 16'h0023);
    gap(g);
    check("R4", g, 8, "divide by 8 spacing");
    wr(4'd0, 16'h0025);            // reserved code
    begin
      logic [15:0] v;
      int moved;
      @(negedge clk);
      v = countValue; moved = 0;
      for (int k = 0; k < 20; k++) begin
        @(negedge clk);
        if (countValue != v) moved++;
      end
      check("R4", moved, 0, "reserved clock code holds");
    end
  endtask

  task automatic t_free_run;
    logic [15:0] prev;
    int bad;
    int above;
    wr(4'd1, 16'd5);
    wr(4'd0, 16'h0000);            // divide by 1, no clear
    @(negedge clk);
    prev = countValue; bad = 0; above = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (countValue != prev + 16'd1) bad++;
      if (countValue > 16'd5) above++;
      prev = countValue;
    end
    check("R6", bad, 0, "free-running increments");
    check("R6", above > 0, 1, "counter passes period without clear");
  endtask

  task automatic ext_run(input logic [1:0] edgeCode, input int expDelta, input string what);
    logic [15:0] start;
    wr(4'd0, 16'h0027 | (16'(edgeCode) << 3));
    idle(4);
    start = countValue;
    for (int p = 0; p < 5; p++) begin
      extClk = 1'b1; idle(4);
      extClk = 1'b0; idle(4);
    end
    idle(4);
    check("R5", int'(countValue - start), expDelta, what);
  endtask

  task automatic t_external;
    wr(4'd1, 16'd1000);
    ext_run(2'b00, 5, "rising edges counted");
    ext_run(2'b01, 5, "falling edges counted");
    ext_run(2'b10, 10, "both edges counted");
  endtask

  initial begin
    idle(3);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_init_levels();
    t_gating();
    t_waveform();
    t_enables();
    t_stop();
    t_prescaler();
    t_free_run();
    t_external();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule